// File: doc/BRIEF.md
# Type 0 Configuration Access Unit

This unit takes a configuration request from a host and runs it as a Type 0 configuration transaction on a simplified bus interface. The host first loads a 32-bit configuration address register. It then strobes a read or a write on the data port. The unit forms the bus address: a one-hot device-select bit in the upper address bits, the function and register numbers passed through, and the two lowest bits forced to zero. It issues a single start pulse and waits for the bus to report completion.

When no target answers, the bus reports a master abort. The unit absorbs it without raising any error. A write finishes as if it had succeeded, and a read returns zero. When the enable bit of the address register is clear, a request never reaches the bus: it completes at once, and a read returns zero. The unit accepts one request at a time and raises a busy flag while a request is in flight.

Top module: `cfg_access_unit`

## Requirements
- R1: After reset, `busy`, `done`, `bus_start` and `data_rdata` are all 0.
- R2: The address register fields are enable [31], bus number [23:16], device [15:11], function [10:8] and register [7:2]. The bus address has bit 16+device set for device 0 to 15, function at [10:8], register at [7:2], and zeros in bits [15:11] and [1:0]. Bus number, reserved bits and register bits [1:0] have no effect on the bus address.
- R3: A device number of 16 to 31 sets no bit in bus address [31:16].
- R4: An enabled request accepted at a clock edge drives `bus_start` high for exactly the following cycle. In that cycle `bus_write` is 1 for a write and 0 for a read, and `bus_wdata` holds the written data.
- R5: Take the edge at which `bus_cmpl` is seen while the unit waits. In the cycle after that edge, `done` is high for exactly one cycle. For a read completed without abort, `data_rdata` then holds the `bus_rdata` that was present at that edge.
- R6: A read completed with `bus_abort`=1 gives `data_rdata`=0 and a normal `done` pulse.
- R7: A write completes with the same `done` timing whether or not `bus_abort` is set. A write, aborted or not, leaves `data_rdata` unchanged.
- R8: A request accepted while enable=0 gives no `bus_start`. `done` is high in the next cycle. A read gives `data_rdata`=0, and a write leaves `data_rdata` unchanged.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. Read or write strobes seen while busy are ignored and start no further transaction.
- R10: If the read and write strobes are high together, the request is taken as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_we | input | 1 | Load the configuration address register |
| cfg_addr_wdata | input | 32 | New configuration address register value |
| data_rd | input | 1 | Read request strobe |
| data_wr | input | 1 | Write request strobe |
| data_wdata | input | 32 | Write data |
| data_rdata | output | 32 | Read result |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion pulse |
| bus_start | output | 1 | One-cycle transaction start |
| bus_write | output | 1 | 1: configuration write, 0: configuration read |
| bus_addr | output | 32 | Generated Type 0 bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_cmpl | input | 1 | Transaction completed |
| bus_abort | input | 1 | Completion was a master abort |
| bus_rdata | input | 32 | Bus read data, valid with `bus_cmpl` |

## Verification
The bench builds the unit with the select field starting at bit 16. This gives sixteen decodable devices and leaves device numbers 16 to 31 without a select bit. It sweeps all 32 device numbers, in both directions, with several function and register values and with a completion delay that varies. Each access is sent to a target that is present or absent, chosen by the device number, so normal completions, aborts, the disabled path, strobes during busy and colliding strobes are all reached.

// File: rtl/cfg_access_unit.sv
module cfg_access_unit #(
  parameter int SEL_LSB = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_addr_we,
  input  logic [31:0] cfg_addr_wdata,
  input  logic        data_rd,
  input  logic        data_wr,
  input  logic [31:0] data_wdata,
  output logic [31:0] data_rdata,
  output logic        busy,
  output logic        done,
  output logic        bus_start,
  output logic        bus_write,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_cmpl,
  input  logic        bus_abort,
  input  logic [31:0] bus_rdata
);
  localparam int SEL_W = 32 - SEL_LSB;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;
  st_t state;

  logic [31:0] addr_reg, req_addr, req_wdata;
  logic        req_write;
  logic        accept;

  function automatic logic [31:0] make_addr(input logic [31:0] a);
    logic [31:0] r;
    r = '0;
    r[10:2] = a[10:2];
    for (int i = 0; i < SEL_W; i++)
      if (a[15:11] == 5'(i)) r[SEL_LSB+i] = 1'b1;
    return r;
  endfunction

  assign accept    = (state == S_IDLE) && (data_rd || data_wr);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign bus_start = (state == S_ISSUE);
  assign bus_write = req_write;
  assign bus_addr  = req_addr;
  assign bus_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_reg <= '0;
    else if (cfg_addr_we) addr_reg <= cfg_addr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      req_addr   <= '0;
      req_wdata  <= '0;
      req_write  <= 1'b0;
      data_rdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          req_write <= data_wr;
          req_wdata <= data_wdata;
          req_addr  <= make_addr(addr_reg);
          if (addr_reg[31]) state <= S_ISSUE;
          else begin
            state <= S_DONE;
            if (!data_wr) data_rdata <= '0;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (bus_cmpl) begin
          state <= S_DONE;
          if (!req_write) data_rdata <= bus_abort ? '0 : bus_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);
  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_addr[31:SEL_LSB]));
  assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> (bus_addr[1:0] == 2'b00 && bus_addr[SEL_LSB-1:11] == '0));
  assert_no_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && addr_reg[15:11] >= 5'(SEL_W)) |=> (bus_addr[31:SEL_LSB] == '0));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_abort_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && bus_cmpl && bus_abort && !req_write) |=> (data_rdata == '0));
  assert_write_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && bus_cmpl && req_write) |=> (done && $stable(data_rdata)));
  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !addr_reg[31]) |=> (done && !bus_start));
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (data_rd || data_wr)) |=> ($stable(req_addr) && $stable(req_write)));
  assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && data_rd && data_wr) |=> bus_write);
endmodule

// File: tb/cfg_access_unit_test.sv
module cfg_access_unit_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_addr_we = 0, data_rd = 0, data_wr = 0;
  logic [31:0] cfg_addr_wdata = 0, data_wdata = 0, bus_rdata = 0;
  logic bus_cmpl = 0, bus_abort = 0;
  logic [31:0] data_rdata, bus_addr, bus_wdata;
  logic busy, done, bus_start, bus_write;
  int total = 0, bad = 0;
  logic [31:0] exp_rd = 0;

  always #(PERIOD/2) clk = ~clk;

  cfg_access_unit #(.SEL_LSB(16)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_addr(input bit en, input int dev, input int fn, input int rg);
    @(negedge clk);
    cfg_addr_we = 1;
    cfg_addr_wdata = {en, 7'h55, 8'hA3, 5'(dev), 3'(fn), 6'(rg), 2'b11};
    @(negedge clk);
    cfg_addr_we = 0;
  endtask

  function automatic logic [31:0] exp_addr(input int dev, input int fn, input int rg);
    logic [31:0] sel;
    sel = (dev < 16) ? (32'd1 << (16 + dev)) : 32'd0;
    return sel | (32'(fn) << 8) | (32'(rg) << 2);
  endfunction

  task automatic txn(input int dev, input int fn, input int rg, input bit wr,
                     input int lat, input bit poke, input bit both);
    bit present;
    logic [31:0] tdata, wd;
    present = (dev < 16) && (dev % 3 != 2);
    tdata = 32'h5A000000 + 32'(dev) * 4096 + 32'(fn) * 256 + 32'(rg);
    wd = 32'hD0000000 ^ 32'(dev * 77 + rg);
    set_addr(1, dev, fn, rg);
    data_rd = !wr || both; data_wr = wr; data_wdata = wd;
    @(negedge clk);
    data_rd = 0; data_wr = 0;
    chk("R4 start", {31'b0, bus_start}, 1);
    chk("R9 busy", {31'b0, busy}, 1);
    chk(dev < 16 ? "R2 addr" : "R3 nosel", bus_addr, exp_addr(dev, fn, rg));
    chk(both ? "R10 write" : "R4 dir", {31'b0, bus_write}, {31'b0, wr});
    if (wr) chk("R4 wdata", bus_wdata, wd);
    for (int i = 0; i < lat; i++) begin
      if (poke && i == 0) data_rd = 1;
      @(negedge clk);
      data_rd = 0;
      chk("R9 no restart", {30'b0, bus_start, busy}, 32'd1);
    end
    @(negedge clk);
    chk("R4 pulse", {31'b0, bus_start}, 0);
    bus_cmpl = 1; bus_abort = !present; bus_rdata = tdata;
    @(negedge clk);
    bus_cmpl = 0; bus_abort = 0; bus_rdata = 32'hFFFFFFFF;
    if (!wr) exp_rd = present ? tdata : 32'd0;
    chk(wr ? "R7 done" : "R5 done", {30'b0, done, busy}, 32'd3);
    chk(wr ? "R7 rdata kept" : (present ? "R5 rdata" : "R6 abort zero"), data_rdata, exp_rd);
    @(negedge clk);
    chk("R5 done pulse", {29'b0, done, busy, bus_start}, 0);
  endtask

  task automatic off_txn(input bit wr);
    set_addr(0, 3, 1, 9);
    data_rd = !wr; data_wr = wr; data_wdata = 32'h12345678;
    @(negedge clk);
    data_rd = 0; data_wr = 0;
    if (!wr) exp_rd = 0;
    chk("R8 done", {29'b0, done, busy, bus_start}, 32'd6);
    chk("R8 rdata", data_rdata, exp_rd);
    @(negedge clk);
    chk("R8 idle", {29'b0, done, busy, bus_start}, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {29'b0, busy, done, bus_start}, 0);
    chk("R1 rdata", data_rdata, 0);
    rst_n = 1;
    for (int dev = 0; dev < 32; dev++)
      for (int k = 0; k < 4; k++)
        txn(dev, (k < 2) ? 0 : dev % 8, (dev * 5 + k * 13) % 64, k[0],
            (dev + k) % 3, (k == 2), 0);
    txn(0, 7, 63, 0, 0, 0, 0);
    off_txn(0);
    txn(1, 2, 3, 0, 1, 0, 0);
    off_txn(1);
    txn(4, 5, 6, 1, 1, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule